// File: doc/BRIEF.md
# Capture-Compare Timer with Toggle Output

This block is a free-running up counter paired with one capture register, two compare registers and a single output flip-flop. A rising edge on an asynchronous trigger pin snapshots the count into the capture register and raises a one-cycle capture event. Software reads the captured count and programs the two compare registers relative to it. With toggling enabled on both compare matches, the output flips once after a chosen delay and flips back after a chosen width. The result is a delayed one-shot pulse whose timing is set by hardware and not by interrupt latency.

A separate option toggles the output directly on the capture event. The pulse then starts with no delay, and only compare register 1 is needed to end it. The prescaler is reduced to a single count-enable tick. Each compare match can also raise its own interrupt line, gated by its own enable bit.

The register port is a plain write strobe with an address and data. A write is accepted in every cycle `wr_en` is high, with no back-pressure, so there is no ready signal. The remaining pins are plain control and status lines.

Top module: `cctimer_top`

## Requirements
- R1: While `rst_n` is low, `cnt_val`, `cap_val`, `tmr_out`, `irq0`, `irq1` and `cap_evt` are all zero, and every register bit is cleared.
- R2: The counter rises by exactly one on each clock edge where the run bit and `tick` are both high. It wraps from 2^W-1 to 0 and is never cleared by a compare match.
- R3: While the run bit (CTRL bit 0) is low, the counter holds its value whatever `tick` does.
- R4: When `trig_in` is first sampled high at edge K after being low, `cap_evt` is high for exactly the one cycle following edge K+3. At that edge `cap_val` loads the count that was held just before the edge, and `cap_val` changes at no other time. A falling edge on `trig_in` captures nothing.
- R5: When the count equals compare register n (n = 0 or 1) in a cycle where counting advances, a match event occurs on the next edge and lasts one cycle. `irq0` shows match 0 AND CTRL bit 4, and `irq1` shows match 1 AND CTRL bit 5.
- R6: `tmr_out` toggles on the edge after a match-0 event when CTRL bit 2 is set, and on the edge after a match-1 event when CTRL bit 3 is set. This allows a delayed pulse whose width in counted ticks is cmp1 - cmp0 (modulo 2^W).
- R7: With CTRL bit 1 set, `tmr_out` toggles on the edge after a capture event.
- R8: Writing CTRL with bit 6 set forces `tmr_out` to 0 on that write's edge, taking priority over any toggle on the same edge. Bit 6 is a command and is not stored.
- R9: A write takes effect on the edge where `wr_en` is high. Address 0 is CTRL, 1 is compare 0, 2 is compare 1, and a write to address 3 changes nothing.
- R10: Toggle sources that coincide on one edge combine by parity. Two simultaneous sources leave `tmr_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable tick |
| trig_in | input | 1 | Asynchronous capture trigger |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 CTRL, 1 CMP0, 2 CMP1) |
| wr_data | input | W | Write data |
| tmr_out | output | 1 | Toggle flip-flop output |
| irq0 | output | 1 | Match-0 interrupt pulse |
| irq1 | output | 1 | Match-1 interrupt pulse |
| cap_evt | output | 1 | One-cycle capture event |
| cap_val | output | W | Captured count |
| cnt_val | output | W | Current count |

## Verification
The assertions assume that `trig_in` only reaches the logic through the two-flop synchroniser, so capture requests can never arrive on back-to-back edges. They also assume every register write completes in the single cycle `wr_en` is high. The stimulus holds `trig_in` at each level for several clocks and drives all inputs on the falling edge. It keeps compare values fixed across each observation window, so every counted match comes from one stable configuration.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCMP    = 2;
  localparam int CLR_BIT = 6;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CMP0 = 2'd1,
    A_CMP1 = 2'd2,
    A_NONE = 2'd3
  } addr_e;

  typedef struct packed {
    logic irq1_en;
    logic irq0_en;
    logic tog_m1;
    logic tog_m0;
    logic tog_cap;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_trig_sync.sv
module tmr_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic rise_q
);
  logic s1, s2, s2_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      s2_d   <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      s1     <= trig_in;
      s2     <= s1;
      s2_d   <= s2;
      rise_q <= s2 & ~s2_d;
    end
  end

  // R4: a detected edge can never repeat on the next cycle
  assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |=> !rise_q);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_addr,
  input  logic [W-1:0]           wr_data,
  output ctrl_t                  ctrl,
  output logic [NCMP-1:0][W-1:0] cmp,
  output logic                   clr_cmd
);
  localparam int CB = $bits(ctrl_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      cmp  <= '0;
    end else if (wr_en) begin
      case (addr_e'(wr_addr))
        A_CTRL:  ctrl   <= ctrl_t'(wr_data[CB-1:0]);
        A_CMP0:  cmp[0] <= wr_data;
        A_CMP1:  cmp[1] <= wr_data;
        default: ;
      endcase
    end
  end

  assign clr_cmd = wr_en && (addr_e'(wr_addr) == A_CTRL) && wr_data[CLR_BIT];

  assert_unused_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=> ($stable(ctrl) && $stable(cmp)));
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   tick,
  input  logic                   cap_req,
  input  logic [NCMP-1:0][W-1:0] cmp,
  output logic [W-1:0]           cnt,
  output logic [W-1:0]           cap,
  output logic                   cap_evt,
  output logic [NCMP-1:0]        match
);
  logic            adv;
  logic [NCMP-1:0] hit;

  assign adv = run & tick;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    assign hit[g] = adv && (cnt == cmp[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cap     <= '0;
      cap_evt <= 1'b0;
      match   <= '0;
    end else begin
      if (adv) cnt <= cnt + 1'b1;
      if (cap_req) cap <= cnt;
      cap_evt <= cap_req;
      match   <= hit;
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> (cnt == W'($past(cnt) + 1'b1)));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && tick) |=> $stable(cnt));
  assert_cap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |-> $stable(cap));
  assert_match0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match[0] |-> ($past(cnt) == $past(cmp[0])));
endmodule

// File: rtl/cctimer_top.sv
module cctimer_top
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             trig_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             tmr_out,
  output logic             irq0,
  output logic             irq1,
  output logic             cap_evt,
  output logic [CNT_W-1:0] cap_val,
  output logic [CNT_W-1:0] cnt_val
);
  ctrl_t                      ctrl;
  logic [NCMP-1:0][CNT_W-1:0] cmp;
  logic                       clr_cmd;
  logic                       rise_q;
  logic [NCMP-1:0]            match;
  logic                       flip;
  logic                       ff_q;

  tmr_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .cmp(cmp), .clr_cmd(clr_cmd)
  );

  tmr_trig_sync u_sync (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .rise_q(rise_q)
  );

  tmr_count #(.W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(tick), .cap_req(rise_q),
    .cmp(cmp), .cnt(cnt_val), .cap(cap_val), .cap_evt(cap_evt), .match(match)
  );

  assign flip = ^{match[0] & ctrl.tog_m0, match[1] & ctrl.tog_m1,
                  cap_evt & ctrl.tog_cap};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ff_q <= 1'b0;
    else if (clr_cmd) ff_q <= 1'b0;
    else              ff_q <= ff_q ^ flip;
  end

  assign tmr_out = ff_q;
  assign irq0    = match[0] & ctrl.irq0_en;
  assign irq1    = match[1] & ctrl.irq1_en;

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> !tmr_out);
  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_cmd && match == '0 && !cap_evt) |=> $stable(tmr_out));
  assert_evt_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> !cap_evt);
endmodule

// File: tb/test_cctimer_top.sv
module test_cctimer_top;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, trig_in = 1'b0, wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic tmr_out, irq0, irq1, cap_evt;
  logic [W-1:0] cap_val, cnt_val;

  always #2 clk = ~clk;

  cctimer_top #(.CNT_W(W)) i_cctimer_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig_in(trig_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .tmr_out(tmr_out), .irq0(irq0),
    .irq1(irq1), .cap_evt(cap_evt), .cap_val(cap_val), .cnt_val(cnt_val)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", r, a, e, $time);
    end
  endtask

  // reference model driven only from the requirements
  logic [W-1:0] e_cnt, e_cap, s_cmp0, s_cmp1;
  logic [5:0]   s_ctrl;
  logic         e_m0, e_m1, e_ce, e_ff;
  logic [4:0]   th;

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      e_cnt = '0; e_cap = '0; s_cmp0 = '0; s_cmp1 = '0; s_ctrl = '0;
      e_m0 = 0; e_m1 = 0; e_ce = 0; e_ff = 0; th = '0;
    end else begin
      logic [4:0] th_n;
      logic adv, n_m0, n_m1, n_ce, clr, n_ff;
      th_n = {th[3:0], trig_in};
      adv  = s_ctrl[0] & tick;
      n_m0 = adv && (e_cnt == s_cmp0);
      n_m1 = adv && (e_cnt == s_cmp1);
      n_ce = th_n[3] & ~th_n[4];
      clr  = wr_en && wr_addr == 2'd0 && wr_data[6];
      n_ff = clr ? 1'b0
                 : e_ff ^ (e_m0 & s_ctrl[2]) ^ (e_m1 & s_ctrl[3]) ^ (e_ce & s_ctrl[1]);
      if (n_ce) e_cap = e_cnt;
      e_cnt = e_cnt + W'(adv);
      if (wr_en) begin
        case (wr_addr)
          2'd0: s_ctrl = wr_data[5:0];
          2'd1: s_cmp0 = wr_data;
          2'd2: s_cmp1 = wr_data;
          default: ;
        endcase
      end
      th = th_n; e_m0 = n_m0; e_m1 = n_m1; e_ce = n_ce; e_ff = n_ff;
      chk("R2 count",   cnt_val, e_cnt);
      chk("R6 output",  tmr_out, e_ff);
      chk("R5 irq0",    irq0, e_m0 & s_ctrl[4]);
      chk("R5 irq1",    irq1, e_m1 & s_ctrl[5]);
      chk("R4 cap_evt", cap_evt, e_ce);
      chk("R4 cap_val", cap_val, e_cap);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] c;
    int k0, k1, hi;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 cnt", cnt_val, 0); chk("R1 cap", cap_val, 0);
    chk("R1 out", tmr_out, 0); chk("R1 irq0", irq0, 0);
    chk("R1 irq1", irq1, 0);   chk("R1 evt", cap_evt, 0);
    @(negedge clk); rst_n = 1; tick = 1;

    idle(6);
    chk("R3 held", cnt_val, 0);

    wr(2'd0, 8'h01);            // run
    idle(300);                  // full wrap
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); tick = (i % 3 != 0);
    end
    @(negedge clk); tick = 1;

    // match sweep over every compare value
    wr(2'd0, 8'h35);
    for (int k = 0; k < 256; k++) begin
      wr(2'd1, W'(k));
      wr(2'd2, W'(k) ^ 8'h5A);
      k0 = 0; k1 = 0;
      repeat (256) begin
        @(posedge clk); #1;
        if (irq0) k0++;
        if (irq1) k1++;
      end
      chk("R5 irq0 per wrap", k0, 1);
      chk("R5 irq1 per wrap", k1, 1);
    end

    // delayed one-shot
    wr(2'd0, 8'h4D);
    @(negedge clk); trig_in = 1;
    do begin @(posedge clk); #1; end while (!cap_evt);
    c = cap_val;
    wr(2'd1, c + 8'd30);
    wr(2'd2, c + 8'd42);
    hi = 0;
    repeat (100) begin
      @(posedge clk); #1;
      if (tmr_out) hi++;
    end
    chk("R6 pulse width", hi, 12);
    @(negedge clk); trig_in = 0;
    idle(6);

    // toggle on capture
    wr(2'd0, 8'h43);
    @(negedge clk); trig_in = 1;
    idle(8);
    chk("R7 toggled on capture", tmr_out, 1);
    @(negedge clk); trig_in = 0;
    idle(6);
    chk("R7 falling edge inert", tmr_out, 1);

    wr(2'd0, 8'h41);
    chk("R8 cleared", tmr_out, 0);

    // unused address
    wr(2'd3, 8'hFF);
    k0 = 0;
    repeat (300) begin
      @(posedge clk); #1;
      if (irq0 || irq1 || tmr_out) k0++;
    end
    chk("R9 address 3 ignored", k0, 0);

    // coincident toggles cancel
    wr(2'd1, 8'h40);
    wr(2'd2, 8'h40);
    wr(2'd0, 8'h0D);
    hi = 0;
    repeat (300) begin
      @(posedge clk); #1;
      if (tmr_out) hi++;
    end
    chk("R10 parity cancel", hi, 0);

    idle(2);
    finish_run();
  end
endmodule